// File: doc/BRIEF.md
# Packed Lane Compare and Bit Merge Unit

This unit performs lane-parallel comparisons on two 64-bit operands and writes a mask word back. Each lane of the mask is filled completely with ones when the lane's condition holds and completely with zeros when it does not. The lanes are either eight 8-bit lanes or four 16-bit lanes. The comparisons are equality and greater-than, and greater-than can be signed or unsigned.

A second operation merges two operands bit by bit under a third mask word. Because a compare produces a full-width lane mask, its result can be fed directly into the merge. This gives branch-free updates, such as keeping the larger of two sets of packed 16-bit depth values.

The result passes through one register stage. An input valid strobe is echoed on the output one cycle later, and a new operation can be accepted on every cycle.

Top module: `simd_cmp_sel`

## Requirements
- R1: With `op`=00 (equal) and `lane_word`=0, result byte lane i (bits 8i+7..8i) is 8'hFF when the A and B bytes of that lane are equal and 8'h00 otherwise.
- R2: With `op`=00 and `lane_word`=1, result 16-bit lane i (bits 16i+15..16i) is 16'hFFFF when the A and B halfwords are equal and 16'h0000 otherwise.
- R3: With `op`=01 (greater-than) and `is_unsigned`=0, each lane is all ones when the A lane is greater than the B lane as a signed two's-complement number, and all zeros otherwise. This holds in both lane sizes.
- R4: With `op`=01 and `is_unsigned`=1, the same comparison is made on unsigned lane values.
- R5: With `op`=10 (merge), the result is (A & MASK) | (B & ~MASK) bit by bit. `lane_word` and `is_unsigned` have no effect on this operation.
- R6: With `op`=11 (reserved), the result is all zeros.
- R7: `out_valid` equals `in_valid` of the previous cycle. The result of an operation accepted on a rising edge is present on `result` after that edge.
- R8: On a cycle where `in_valid` is low, `result` keeps its previous value, whatever the other inputs are.
- R9: While `rst_n` is low, `out_valid` is 0 and `result` is 0.
- R10: Every compare result consists of lanes that are each uniformly all ones or all zeros, at the lane size selected.
- R11: Swapping A and B in a greater-than compare and inverting the result gives the greater-or-equal mask for A against B, for both signednesses and both lane sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| op | input | 2 | 00 equal, 01 greater-than, 10 merge, 11 reserved |
| is_unsigned | input | 1 | Greater-than treats lanes as unsigned when 1 |
| lane_word | input | 1 | 0: eight byte lanes, 1: four 16-bit lanes |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B |
| mask | input | 64 | Merge mask (bit 1 takes A, bit 0 takes B) |
| out_valid | output | 1 | Result register holds a new operation |
| result | output | 64 | Registered result |

## Verification
The hardest cases to reach are the signed boundaries, where lanes at 0x7F/0x80 or 0x7FFF/0x8000 must order one way when signed and the other way when unsigned. Random data seldom lands on these values in every lane at once. The byte sweep therefore pairs every possible A byte with every possible B byte, placing eight pairs per operation, so all 65,536 pairs are covered in each compare mode. The word mode draws from a list of boundary halfwords mixed with pseudo-random values. The greater-or-equal identity is checked by driving swapped operands and comparing the inverted mask against an arithmetic reference.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;
  typedef enum logic [1:0] {
    OP_EQ  = 2'b00,
    OP_GT  = 2'b01,
    OP_SEL = 2'b10,
    OP_RSV = 2'b11
  } op_e;
endpackage

// File: rtl/simd_lane_cmp.sv
module simd_lane_cmp #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] lane_a,
  input  logic [LANE_W-1:0] lane_b,
  input  logic              is_unsigned,
  output logic              eq,
  output logic              gt
);
  logic [LANE_W-1:0] bias_a;
  logic [LANE_W-1:0] bias_b;

  // Flipping the sign bit maps signed order onto unsigned order.
  always_comb begin
    bias_a = lane_a;
    bias_b = lane_b;
    bias_a[LANE_W-1] = lane_a[LANE_W-1] ^ ~is_unsigned;
    bias_b[LANE_W-1] = lane_b[LANE_W-1] ^ ~is_unsigned;
    eq = (lane_a == lane_b);
    gt = (bias_a > bias_b);
  end
endmodule

// File: rtl/simd_cmp_array.sv
module simd_cmp_array #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              is_unsigned,
  output logic [DATA_W-1:0] eq_mask,
  output logic [DATA_W-1:0] gt_mask
);
  localparam int NLANES = DATA_W / LANE_W;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic eq_l;
    logic gt_l;
    simd_lane_cmp #(.LANE_W(LANE_W)) u_cmp (
      .lane_a     (opa[i*LANE_W +: LANE_W]),
      .lane_b     (opb[i*LANE_W +: LANE_W]),
      .is_unsigned(is_unsigned),
      .eq         (eq_l),
      .gt         (gt_l)
    );
    assign eq_mask[i*LANE_W +: LANE_W] = {LANE_W{eq_l}};
    assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{gt_l}};
  end
endmodule

// File: rtl/simd_bitsel.sv
module simd_bitsel #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] take_a,
  input  logic [DATA_W-1:0] take_b,
  input  logic [DATA_W-1:0] sel,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    merged = (take_a & sel) | (take_b & ~sel);
  end
endmodule

// File: rtl/simd_cmp_sel.sv
module simd_cmp_sel
  import simd_cmp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              is_unsigned,
  input  logic              lane_word,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] mask,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] byte_eq, byte_gt;
  logic [DATA_W-1:0] word_eq, word_gt;
  logic [DATA_W-1:0] merge_d;
  logic [DATA_W-1:0] result_d, result_q;
  logic              valid_q;
  op_e               op_sel;

  simd_cmp_array #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_bytes (
    .opa(a), .opb(b), .is_unsigned(is_unsigned),
    .eq_mask(byte_eq), .gt_mask(byte_gt)
  );

  simd_cmp_array #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_words (
    .opa(a), .opb(b), .is_unsigned(is_unsigned),
    .eq_mask(word_eq), .gt_mask(word_gt)
  );

  simd_bitsel #(.DATA_W(DATA_W)) u_merge (
    .take_a(a), .take_b(b), .sel(mask), .merged(merge_d)
  );

  // Next-state selection
  always_comb begin
    op_sel = op_e'(op);
    unique case (op_sel)
      OP_EQ:   result_d = lane_word ? word_eq : byte_eq;
      OP_GT:   result_d = lane_word ? word_gt : byte_gt;
      OP_SEL:  result_d = merge_d;
      default: result_d = '0;
    endcase
  end

  // Result register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (in_valid) begin
      result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
endmodule

// File: rtl/simd_cmp_sel_chk.sv
module simd_cmp_sel_chk #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic              lane_word,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [DATA_W-1:0] mask,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  function automatic logic lanes_uniform(input logic [DATA_W-1:0] v, input logic wide);
    logic ok;
    ok = 1'b1;
    if (wide) begin
      for (int i = 0; i < DATA_W / WORD_W; i++)
        if (v[i*WORD_W +: WORD_W] != '0 && v[i*WORD_W +: WORD_W] != '1) ok = 1'b0;
    end else begin
      for (int i = 0; i < DATA_W / BYTE_W; i++)
        if (v[i*BYTE_W +: BYTE_W] != '0 && v[i*BYTE_W +: BYTE_W] != '1) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  a_r5_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b10) |=> (result == (($past(a) & $past(mask)) | ($past(b) & ~$past(mask)))));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b11) |=> (result == '0));

  a_r10_lane_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[1]) |=> lanes_uniform(result, $past(lane_word)));
endmodule

bind simd_cmp_sel simd_cmp_sel_chk #(
  .DATA_W(DATA_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .lane_word(lane_word), .a(a), .b(b), .mask(mask),
  .out_valid(out_valid), .result(result)
);

// File: tb/tb_simd_cmp_sel.sv
module tb_simd_cmp_sel;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic        is_unsigned;
  logic        lane_word;
  logic [63:0] a, b, mask;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  simd_cmp_sel dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .is_unsigned(is_unsigned), .lane_word(lane_word),
    .a(a), .b(b), .mask(mask), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] ref_model(input logic [1:0] o, input logic uns,
                                            input logic lw, input logic [63:0] x,
                                            input logic [63:0] y, input logic [63:0] m);
    int w;
    longint vx, vy;
    logic [63:0] r;
    if (o == 2'b10) return (x & m) | (y & ~m);
    if (o == 2'b11) return 64'd0;
    w = lw ? 16 : 8;
    r = '0;
    for (int i = 0; i < 64 / w; i++) begin
      vx = longint'((x >> (i * w)) & ((64'd1 << w) - 1));
      vy = longint'((y >> (i * w)) & ((64'd1 << w) - 1));
      if (!uns) begin
        if (vx >= (longint'(1) << (w - 1))) vx = vx - (longint'(1) << w);
        if (vy >= (longint'(1) << (w - 1))) vy = vy - (longint'(1) << w);
      end
      if ((o == 2'b00 && vx == vy) || (o == 2'b01 && vx > vy))
        r = r | (((64'd1 << w) - 1) << (i * w));
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_ge(input logic uns, input logic lw,
                                         input logic [63:0] x, input logic [63:0] y);
    return ref_model(2'b01, uns, lw, x, y, '0) | ref_model(2'b00, uns, lw, x, y, '0);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_rand(output logic [63:0] v);
    for (int k = 0; k < 2; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = {v[31:0], lfsr ^ 32'h5A5A_0F0F * (k + 1)};
    end
  endtask

  // Issue one operation and check the registered result and valid.
  task automatic run_op(input string req, input logic [1:0] o, input logic uns,
                        input logic lw, input logic [63:0] x, input logic [63:0] y,
                        input logic [63:0] m);
    @(negedge clk);
    in_valid = 1'b1; op = o; is_unsigned = uns; lane_word = lw;
    a = x; b = y; mask = m;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, result, ref_model(o, uns, lw, x, y, m));
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] x, y, held, r1, r2;
    logic [15:0] corners [8];
    corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF;
    corners[3] = 16'h8000; corners[4] = 16'hFFFF; corners[5] = 16'h8001;
    corners[6] = 16'h7FFE; corners[7] = 16'h00FF;

    rst_n = 1'b0; in_valid = 1'b0; op = 2'b00; is_unsigned = 1'b0;
    lane_word = 1'b0; a = '0; b = '0; mask = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R9 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 idle after reset", {63'd0, out_valid}, 64'd0);

    // R1, R3, R4, R10: every byte pair, eight pairs per operation
    for (int xa = 0; xa < 256; xa++) begin
      for (int yb = 0; yb < 32; yb++) begin
        x = {8{xa[7:0]}};
        for (int j = 0; j < 8; j++) y[j*8 +: 8] = 8'(yb * 8 + j);
        run_op("R1 byte equal", 2'b00, 1'b0, 1'b0, x, y, '0);
        run_op("R3 byte signed gt", 2'b01, 1'b0, 1'b0, x, y, '0);
        run_op("R4 byte unsigned gt", 2'b01, 1'b1, 1'b0, x, y, '0);
      end
    end

    // R2, R3, R4: halfword corners crossed, lanes rotated
    for (int p = 0; p < 8; p++) begin
      for (int q = 0; q < 8; q++) begin
        x = {corners[p], corners[q], corners[(p+1)%8], corners[q]};
        y = {corners[q], corners[q], corners[p], corners[(q+3)%8]};
        run_op("R2 word equal", 2'b00, 1'b0, 1'b1, x, y, '0);
        run_op("R3 word signed gt", 2'b01, 1'b0, 1'b1, x, y, '0);
        run_op("R4 word unsigned gt", 2'b01, 1'b1, 1'b1, x, y, '0);
      end
    end
    for (int n = 0; n < 400; n++) begin
      next_rand(x); next_rand(y);
      if (n % 4 == 0) y[31:16] = x[31:16];
      run_op("R2 word equal rand", 2'b00, 1'b0, 1'b1, x, y, '0);
      run_op("R3 word signed gt rand", 2'b01, 1'b0, 1'b1, x, y, '0);
      run_op("R4 word unsigned gt rand", 2'b01, 1'b1, 1'b1, x, y, '0);
    end

    // R5: merge, with lane_word and is_unsigned varied
    for (int n = 0; n < 200; n++) begin
      next_rand(x); next_rand(y); next_rand(r1);
      run_op("R5 merge", 2'b10, n[0], n[1], x, y, r1);
    end
    run_op("R5 merge all A", 2'b10, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, '1);
    run_op("R5 merge all B", 2'b10, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, '0);

    // Compare then merge: keep larger signed depths
    x = 64'h7FFF_8000_0010_FFFE; y = 64'h8000_7FFF_0020_FFFF;
    run_op("R3 depth compare", 2'b01, 1'b0, 1'b1, x, y, '0);
    r1 = result;
    run_op("R5 depth keep max", 2'b10, 1'b0, 1'b1, x, y, r1);
    check("R5 depth max value", result, 64'h7FFF_7FFF_0020_FFFF);

    // R6: reserved opcode
    for (int n = 0; n < 20; n++) begin
      next_rand(x); next_rand(y);
      run_op("R6 reserved", 2'b11, n[0], n[1], x, y, x);
    end

    // R11: greater-or-equal through swapped greater-than
    for (int n = 0; n < 300; n++) begin
      next_rand(x); next_rand(y);
      if (n % 3 == 0) y = x;
      if (n % 5 == 1) y[15:0] = x[15:0];
      @(negedge clk);
      in_valid = 1'b1; op = 2'b01; is_unsigned = n[0]; lane_word = n[1];
      a = y; b = x; mask = '0;
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 ge identity", ~result, ref_ge(n[0], n[1], x, y));
    end

    // R8: result holds while in_valid is low
    run_op("R8 setup", 2'b10, 1'b0, 1'b0, 64'hDEAD_BEEF_0000_1111, 64'h0, '1);
    held = result;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      next_rand(r2);
      op = 2'(n); a = r2; b = ~r2; mask = r2;
      @(negedge clk);
      check("R8 result held", result, held);
      check("R7 no valid when idle", {63'd0, out_valid}, 64'd0);
    end

    // R7: back-to-back operations
    @(negedge clk);
    in_valid = 1'b1; op = 2'b10; a = 64'h1111; b = '0; mask = '1;
    @(negedge clk);
    check("R7 first of pair", result, 64'h1111);
    a = 64'h2222;
    @(negedge clk);
    check("R7 second of pair", result, 64'h2222);
    check("R7 valid held", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 valid drops", {63'd0, out_valid}, 64'd0);

    // R9: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R9 async reset result", result, 64'd0);
    check("R9 async reset valid", {63'd0, out_valid}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule